// File: doc/BRIEF.md
# Receive Page Pointer with Frame Rollback

This block generates the byte address for a receive DMA engine that stores incoming frames into a ring of 256-byte pages in local buffer memory. It keeps two page values: a first-page register that marks where the frame now being stored began, and a working DMA pointer (page plus in-page offset) that moves forward one byte per write strobe. Each frame leaves the first few bytes of its first page free for a header and starts its data just after them. When the working page runs off the last ring page, it wraps back to the ring start page.

When the receiver reports a flawed frame, the working pointer is rewound to the first page of that frame, so every page the frame touched is reused by the next frame. When the receiver reports a good frame, the block enters a short header phase. During that phase the output address walks through the header bytes at offset zero of the frame's first page. After the last header byte, the first-page register moves on to the page after the last page the frame used. Software sets the first-page register once, to the ring start page, after reset. That write also places the working pointer at the same page.

Top module: `rpp_rx_page_ptr`

## Requirements
- R1: After reset, cur_page_o, mem_addr_o and hdr_busy_o are all zero. Until the first host write, byte strobes and frame status inputs leave every output unchanged.
- R2: A host write (host_cur_we_i=1) takes precedence over all other inputs in that cycle, including during the header phase. One cycle later, cur_page_o equals host_cur_data_i, mem_addr_o equals {host_cur_data_i, 8'h04} and hdr_busy_o is 0.
- R3: In the data phase, a byte strobe with no other event moves mem_addr_o forward by one on the next cycle. From offset 8'hFF, the offset goes to 8'h00 on the successor page.
- R4: The successor of page p is ring_start_i when p+1 equals ring_stop_i, and p+1 otherwise. The ring therefore spans pages ring_start_i to ring_stop_i-1.
- R5: In the data phase, frame_bad_i sets mem_addr_o to {cur_page_o, 8'h04} on the next cycle and leaves cur_page_o unchanged. It wins over frame_good_i and over a byte strobe in the same cycle.
- R6: In the data phase, frame_good_i (without frame_bad_i) raises hdr_busy_o on the next cycle, and mem_addr_o becomes {cur_page_o, 8'h00}; a byte strobe in the same cycle is dropped. While hdr_busy_o is 1, each byte strobe advances the offset by one through 0 to 3.
- R7: The cycle after the fourth header strobe, hdr_busy_o is 0 and cur_page_o is the page after the last data page used. That page is the working page if the working offset was 8'h00 when the good status arrived, and its successor otherwise. mem_addr_o is then {cur_page_o, 8'h04}.
- R8: While hdr_busy_o is 1, frame_good_i and frame_bad_i have no effect on any output.
- R9: cur_page_o changes only on a host write or on header completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_start_i | input | 8 | First page of the receive ring |
| ring_stop_i | input | 8 | Page just past the last ring page |
| host_cur_we_i | input | 1 | Host write to the first-page register |
| host_cur_data_i | input | 8 | Page value of the host write |
| byte_we_i | input | 1 | A byte is written at mem_addr_o this cycle |
| frame_good_i | input | 1 | Frame ended without error |
| frame_bad_i | input | 1 | Frame ended with error; discard it |
| mem_addr_o | output | 16 | Buffer memory byte address |
| cur_page_o | output | 8 | First page of the frame being stored |
| hdr_busy_o | output | 1 | Header bytes are being addressed |

## Verification
The assertions assume that the ring bounds stay fixed while the block is running and that ring_start_i is below ring_stop_i. They also assume that every host write carries a page inside the ring. Only under those conditions can the pages on mem_addr_o and cur_page_o be held inside the ring. The stimulus sets one ring per run, writes only the start page or another in-ring page, and only then raises byte strobes and frame status. Stray status pulses are still injected during the header phase and before initialisation, because the block must ignore them.

// File: rtl/rpp_pkg.sv
package rpp_pkg;

    typedef enum logic [1:0] {
        ST_UNINIT = 2'd0,
        ST_FILL   = 2'd1,
        ST_HDR    = 2'd2
    } rpp_state_e;

    typedef enum logic [2:0] {
        ACT_IDLE   = 3'd0,
        ACT_LOAD   = 3'd1,
        ACT_REWIND = 3'd2,
        ACT_COMMIT = 3'd3,
        ACT_DATA   = 3'd4,
        ACT_HDR    = 3'd5
    } rpp_act_e;

    typedef struct packed {
        logic load;
        logic bad;
        logic good;
        logic strobe;
    } rpp_req_t;

    // Fixed priority: host load, then flawed frame, then good frame, then byte
    function automatic rpp_act_e rpp_decide(rpp_state_e st, rpp_req_t rq);
        rpp_act_e a;
        a = ACT_IDLE;
        if (rq.load) begin
            a = ACT_LOAD;
        end else begin
            unique case (st)
                ST_FILL: begin
                    if (rq.bad)         a = ACT_REWIND;
                    else if (rq.good)   a = ACT_COMMIT;
                    else if (rq.strobe) a = ACT_DATA;
                end
                ST_HDR: begin
                    if (rq.strobe)      a = ACT_HDR;
                end
                default: a = ACT_IDLE;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/rpp_evt_arb.sv
module rpp_evt_arb
    import rpp_pkg::*;
(
    input  rpp_state_e state_i,
    input  logic       load_i,
    input  logic       bad_i,
    input  logic       good_i,
    input  logic       strobe_i,
    output rpp_act_e   act_o
);
    rpp_req_t req;

    always_comb begin
        req.load   = load_i;
        req.bad    = bad_i;
        req.good   = good_i;
        req.strobe = strobe_i;
        act_o      = rpp_decide(state_i, req);
    end
endmodule

// File: rtl/rpp_page_succ.sv
module rpp_page_succ #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [PAGE_W-1:0] start_i,
    input  logic [PAGE_W-1:0] stop_i,
    output logic [PAGE_W-1:0] succ_o
);
    logic [PAGE_W-1:0] inc;

    always_comb begin
        inc    = page_i + {{(PAGE_W-1){1'b0}}, 1'b1};
        succ_o = (inc == stop_i) ? start_i : inc;
    end
endmodule

// File: rtl/rpp_ptr_core.sv
module rpp_ptr_core
    import rpp_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int OFS_W     = 8,
    parameter int HDR_BYTES = 4,
    localparam int HCNT_W   = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  rpp_act_e          act_i,
    input  logic [PAGE_W-1:0] load_page_i,
    input  logic [PAGE_W-1:0] succ_i,
    output rpp_state_e        state_o,
    output logic [PAGE_W-1:0] cur_o,
    output logic [PAGE_W-1:0] pg_o,
    output logic [OFS_W-1:0]  ofs_o,
    output logic [HCNT_W-1:0] hcnt_o
);
    localparam logic [OFS_W-1:0]  DATA_OFS = OFS_W'(HDR_BYTES);
    localparam logic [OFS_W-1:0]  OFS_MAX  = {OFS_W{1'b1}};
    localparam logic [HCNT_W-1:0] HCNT_END = HCNT_W'(HDR_BYTES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= ST_UNINIT;
            cur_o   <= '0;
            pg_o    <= '0;
            ofs_o   <= '0;
            hcnt_o  <= '0;
        end else begin
            unique case (act_i)
                ACT_LOAD: begin
                    cur_o   <= load_page_i;
                    pg_o    <= load_page_i;
                    ofs_o   <= DATA_OFS;
                    hcnt_o  <= '0;
                    state_o <= ST_FILL;
                end
                ACT_REWIND: begin
                    pg_o  <= cur_o;
                    ofs_o <= DATA_OFS;
                end
                ACT_COMMIT: begin
                    // pg_o holds the next frame's first page during the header phase
                    pg_o    <= (ofs_o == '0) ? pg_o : succ_i;
                    ofs_o   <= DATA_OFS;
                    hcnt_o  <= '0;
                    state_o <= ST_HDR;
                end
                ACT_DATA: begin
                    if (ofs_o == OFS_MAX) begin
                        ofs_o <= '0;
                        pg_o  <= succ_i;
                    end else begin
                        ofs_o <= ofs_o + {{(OFS_W-1){1'b0}}, 1'b1};
                    end
                end
                ACT_HDR: begin
                    if (hcnt_o == HCNT_END) begin
                        cur_o   <= pg_o;
                        hcnt_o  <= '0;
                        state_o <= ST_FILL;
                    end else begin
                        hcnt_o <= hcnt_o + {{(HCNT_W-1){1'b0}}, 1'b1};
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rpp_rx_page_ptr.sv
module rpp_rx_page_ptr
    import rpp_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int OFS_W     = 8,
    parameter int HDR_BYTES = 4,
    localparam int ADDR_W   = PAGE_W + OFS_W,
    localparam int HCNT_W   = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] ring_start_i,
    input  logic [PAGE_W-1:0] ring_stop_i,
    input  logic              host_cur_we_i,
    input  logic [PAGE_W-1:0] host_cur_data_i,
    input  logic              byte_we_i,
    input  logic              frame_good_i,
    input  logic              frame_bad_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [PAGE_W-1:0] cur_page_o,
    output logic              hdr_busy_o
);
    rpp_state_e        state;
    rpp_act_e          act;
    logic [PAGE_W-1:0] cur_pg;
    logic [PAGE_W-1:0] dma_pg;
    logic [OFS_W-1:0]  dma_ofs;
    logic [HCNT_W-1:0] hcnt;
    logic [PAGE_W-1:0] succ_pg;

    rpp_evt_arb u_arb (
        .state_i  (state),
        .load_i   (host_cur_we_i),
        .bad_i    (frame_bad_i),
        .good_i   (frame_good_i),
        .strobe_i (byte_we_i),
        .act_o    (act)
    );

    rpp_page_succ #(.PAGE_W(PAGE_W)) u_succ (
        .page_i  (dma_pg),
        .start_i (ring_start_i),
        .stop_i  (ring_stop_i),
        .succ_o  (succ_pg)
    );

    rpp_ptr_core #(
        .PAGE_W    (PAGE_W),
        .OFS_W     (OFS_W),
        .HDR_BYTES (HDR_BYTES)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .act_i       (act),
        .load_page_i (host_cur_data_i),
        .succ_i      (succ_pg),
        .state_o     (state),
        .cur_o       (cur_pg),
        .pg_o        (dma_pg),
        .ofs_o       (dma_ofs),
        .hcnt_o      (hcnt)
    );

    always_comb begin
        hdr_busy_o = (state == ST_HDR);
        cur_page_o = cur_pg;
        if (hdr_busy_o) mem_addr_o = {cur_pg, OFS_W'(hcnt)};
        else            mem_addr_o = {dma_pg, dma_ofs};
    end
endmodule

// File: rtl/rpp_rx_page_ptr_chk.sv
module rpp_rx_page_ptr_chk #(
    parameter int PAGE_W    = 8,
    parameter int OFS_W     = 8,
    parameter int HDR_BYTES = 4,
    localparam int ADDR_W   = PAGE_W + OFS_W,
    localparam int CW       = $clog2(HDR_BYTES + 1) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [PAGE_W-1:0] ring_start_i,
    input logic [PAGE_W-1:0] ring_stop_i,
    input logic              host_cur_we_i,
    input logic [PAGE_W-1:0] host_cur_data_i,
    input logic              byte_we_i,
    input logic              frame_good_i,
    input logic              frame_bad_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [PAGE_W-1:0] cur_page_o,
    input logic              hdr_busy_o
);
    logic          inited;
    logic [CW-1:0] hseen;

    always_ff @(posedge clk) begin
        if (rst) begin
            inited <= 1'b0;
            hseen  <= '0;
        end else begin
            if (host_cur_we_i) inited <= 1'b1;
            if (host_cur_we_i || !hdr_busy_o) hseen <= '0;
            else if (byte_we_i)               hseen <= hseen + 1'b1;
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!inited && !host_cur_we_i) |=> ($stable(mem_addr_o) && $stable(cur_page_o) && !hdr_busy_o)); // R1

    AST_HOST_LOAD: assert property (@(posedge clk) disable iff (rst)
        host_cur_we_i |=> (cur_page_o == $past(host_cur_data_i) && !hdr_busy_o
                           && mem_addr_o == {$past(host_cur_data_i), OFS_W'(HDR_BYTES)})); // R2

    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
        (inited && !hdr_busy_o && byte_we_i && !frame_good_i && !frame_bad_i && !host_cur_we_i
         && mem_addr_o[OFS_W-1:0] != {OFS_W{1'b1}}) |=> (mem_addr_o == $past(mem_addr_o) + 1'b1)); // R3

    AST_IN_RING: assert property (@(posedge clk) disable iff (rst)
        inited |-> (cur_page_o >= ring_start_i && cur_page_o < ring_stop_i
                    && mem_addr_o[ADDR_W-1:OFS_W] >= ring_start_i
                    && mem_addr_o[ADDR_W-1:OFS_W] < ring_stop_i)); // R4

    AST_BAD_REWIND: assert property (@(posedge clk) disable iff (rst)
        (inited && frame_bad_i && !hdr_busy_o && !host_cur_we_i)
        |=> (mem_addr_o == {$past(cur_page_o), OFS_W'(HDR_BYTES)} && $stable(cur_page_o))); // R5

    AST_GOOD_ENTER: assert property (@(posedge clk) disable iff (rst)
        (inited && frame_good_i && !frame_bad_i && !hdr_busy_o && !host_cur_we_i)
        |=> (hdr_busy_o && mem_addr_o == {cur_page_o, {OFS_W{1'b0}}})); // R6

    AST_HDR_EXIT: assert property (@(posedge clk) disable iff (rst)
        (hdr_busy_o && byte_we_i && !host_cur_we_i && hseen == CW'(HDR_BYTES - 1))
        |=> (!hdr_busy_o && mem_addr_o == {cur_page_o, OFS_W'(HDR_BYTES)})); // R7

    AST_HDR_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (hdr_busy_o && !byte_we_i && !host_cur_we_i)
        |=> (hdr_busy_o && $stable(mem_addr_o) && $stable(cur_page_o))); // R8

    AST_CUR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!host_cur_we_i && !hdr_busy_o) |=> $stable(cur_page_o)); // R9
endmodule

bind rpp_rx_page_ptr rpp_rx_page_ptr_chk #(
    .PAGE_W    (PAGE_W),
    .OFS_W     (OFS_W),
    .HDR_BYTES (HDR_BYTES)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .ring_start_i    (ring_start_i),
    .ring_stop_i     (ring_stop_i),
    .host_cur_we_i   (host_cur_we_i),
    .host_cur_data_i (host_cur_data_i),
    .byte_we_i       (byte_we_i),
    .frame_good_i    (frame_good_i),
    .frame_bad_i     (frame_bad_i),
    .mem_addr_o      (mem_addr_o),
    .cur_page_o      (cur_page_o),
    .hdr_busy_o      (hdr_busy_o)
);

// File: tb/rpp_rx_page_ptr_tb.sv
`timescale 1ns/1ps
module rpp_rx_page_ptr_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ring_start = 8'h20;
    logic [7:0]  ring_stop  = 8'h28;
    logic        host_we = 1'b0;
    logic [7:0]  host_d  = 8'h00;
    logic        bwe  = 1'b0;
    logic        good = 1'b0;
    logic        bad  = 1'b0;
    logic [15:0] addr;
    logic [7:0]  curp;
    logic        busy;

    int checks = 0;
    int errors = 0;

    // bench model of the requirements
    logic       m_init = 1'b0;
    logic       m_hdr  = 1'b0;
    logic [7:0] m_cur  = 8'h00;
    logic [7:0] m_pg   = 8'h00;
    logic [7:0] m_ofs  = 8'h00;
    logic [7:0] m_next = 8'h00;
    int         m_h    = 0;

    always #5 clk = ~clk;

    rpp_rx_page_ptr u_dut (
        .clk             (clk),
        .rst             (rst),
        .ring_start_i    (ring_start),
        .ring_stop_i     (ring_stop),
        .host_cur_we_i   (host_we),
        .host_cur_data_i (host_d),
        .byte_we_i       (bwe),
        .frame_good_i    (good),
        .frame_bad_i     (bad),
        .mem_addr_o      (addr),
        .cur_page_o      (curp),
        .hdr_busy_o      (busy)
    );

    function automatic logic [7:0] succ(input logic [7:0] p);
        logic [7:0] n;
        n = p + 8'd1;
        return (n == ring_stop) ? ring_start : n;
    endfunction

    function automatic logic [15:0] exp_addr();
        return m_hdr ? {m_cur, 8'(m_h)} : {m_pg, m_ofs};
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "mem_addr_o", addr, exp_addr());
        check(tag, "cur_page_o", {8'h00, curp}, {8'h00, m_cur});
        check(tag, "hdr_busy_o", {15'h0, busy}, {15'h0, m_hdr});
    endtask

    // one cycle: drive at negedge, model the edge, compare at next negedge
    task automatic cyc(input logic hw, input logic [7:0] hd, input logic bw, input logic gd, input logic bd);
        string tag;
        if (hw)                          tag = "R2";
        else if (!m_init)                tag = "R1";
        else if (m_hdr && bw && m_h == 3) tag = "R7";
        else if (m_hdr && (gd || bd))    tag = "R8";
        else if (m_hdr)                  tag = "R6";
        else if (bd)                     tag = "R5";
        else if (gd)                     tag = "R6";
        else if (bw && m_ofs == 8'hFF && m_pg + 8'd1 == ring_stop) tag = "R4";
        else if (bw)                     tag = "R3";
        else                             tag = "R9";
        host_we = hw; host_d = hd; bwe = bw; good = gd; bad = bd;
        @(posedge clk);
        if (hw) begin
            m_init = 1'b1; m_hdr = 1'b0; m_cur = hd; m_pg = hd; m_ofs = 8'd4; m_h = 0;
        end else if (m_init && !m_hdr) begin
            if (bd) begin
                m_pg = m_cur; m_ofs = 8'd4;
            end else if (gd) begin
                m_next = (m_ofs == 8'h00) ? m_pg : succ(m_pg);
                m_pg = m_next; m_ofs = 8'd4; m_hdr = 1'b1; m_h = 0;
            end else if (bw) begin
                if (m_ofs == 8'hFF) begin m_ofs = 8'h00; m_pg = succ(m_pg); end
                else m_ofs = m_ofs + 8'd1;
            end
        end else if (m_init && m_hdr && bw) begin
            if (m_h == 3) begin m_hdr = 1'b0; m_cur = m_pg; m_h = 0; end
            else m_h = m_h + 1;
        end
        @(negedge clk);
        host_we = 1'b0; bwe = 1'b0; good = 1'b0; bad = 1'b0;
        compare(tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        compare("R1");
        // R1: activity before the first host write is ignored
        cyc(0, 8'h00, 1, 0, 0);
        cyc(0, 8'h00, 0, 1, 0);
        cyc(0, 8'h00, 0, 0, 1);
        // R2: load, then run to the last ring page boundary (R4 wrap)
        cyc(1, 8'h27, 0, 0, 0);
        for (int i = 0; i < 252; i++) cyc(0, 8'h00, 1, 0, 0);
        check("R4", "wrap address", addr, 16'h2000);
        // R5: bad frame together with a byte strobe
        cyc(0, 8'h00, 1, 0, 1);
        check("R5", "rewind address", addr, 16'h2704);
        // R6/R7: empty good frame, stray status during header (R8)
        cyc(0, 8'h00, 1, 1, 0);
        check("R6", "header start", addr, 16'h2700);
        cyc(0, 8'h00, 0, 1, 1);
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 1, 0, 0);
        check("R7", "new first page", {8'h00, curp}, 16'h0020);
        // R7: frame ending exactly on a page boundary
        for (int i = 0; i < 252; i++) cyc(0, 8'h00, 1, 0, 0);
        cyc(0, 8'h00, 0, 1, 0);
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 1, 0, 0);
        check("R7", "boundary first page", {8'h00, curp}, 16'h0021);
        // R2: host write abandons a header phase
        cyc(0, 8'h00, 0, 1, 0);
        cyc(0, 8'h00, 1, 0, 0);
        cyc(1, 8'h20, 1, 1, 1);
        check("R2", "load over header", addr, 16'h2004);
        // random frames
        for (int f = 0; f < 45; f++) begin
            int len;
            len = $urandom_range(0, 640);
            for (int b = 0; b < len; b++) begin
                if ($urandom_range(0, 9) < 3) cyc(0, 8'h00, 0, 0, 0);
                cyc(0, 8'h00, 1, 0, 0);
            end
            if ($urandom_range(0, 3) == 0) begin
                cyc(0, 8'h00, $urandom_range(0, 1), $urandom_range(0, 1), 1);
            end else begin
                cyc(0, 8'h00, $urandom_range(0, 1), 1, 0);
                for (int h = 0; h < 4; h++) begin
                    if ($urandom_range(0, 3) == 0)
                        cyc(0, 8'h00, 0, $urandom_range(0, 1), $urandom_range(0, 1));
                    cyc(0, 8'h00, 1, 0, 0);
                end
            end
        end
        summary();
        $finish;
    end
endmodule